// File: doc/BRIEF.md
# Pulse Add/Delete Frequency Halver

This block is the increment/decrement stage of an all-digital phase-locked loop. It runs from a fast I/D clock and drives an output pulse train. With nothing to correct, it gives exactly one output pulse for every two I/D clock cycles, so the output runs at half the I/D clock. The I/D clock is 2N times the loop centre frequency, so the idle output is N times the centre frequency. A divide-by-N counter outside the block follows it.

Two request inputs, carry and borrow, steer the output frequency. They come from an up/down counter outside the block. Each carry request inserts one output pulse into the stream, and each borrow request removes one. Over a long interval the average output rate is therefore the idle rate plus half the net rate of carries minus borrows, measured per I/D cycle.

Requests may arrive at any phase. The block synchronises them to the I/D clock, detects their rising edges and keeps them in a signed pending count until they are serviced. Each output pulse lasts for the low half of an I/D clock cycle. An internal phase bit sets which low halves carry a pulse. Normally this bit toggles on every rising edge. A carry is serviced by holding the bit high across one extra edge. A borrow is serviced by holding it low across one extra edge.

Top module: `idPulseAdjuster`

## Requirements
- R1: With no requests after reset, the output pulse appears in every second I/D clock low phase. The first pulse falls in the low phase of the first cycle after reset is released. No two neighbouring low phases ever hold the same level.
- R2: The output is low whenever the I/D clock is high. A pulse is at most the width of one I/D clock low phase.
- R3: Each carry request produces exactly one extra pulse. The extra pulse shows as one pair of neighbouring low phases that both carry a pulse.
- R4: Each borrow request removes exactly one pulse. The removal shows as one pair of neighbouring low phases that both lack a pulse.
- R5: Requests are latched in a pending count, so back-to-back requests spaced one cycle apart are all serviced and none is lost. A request must be high for at least one I/D cycle and low for at least one cycle between requests.
- R6: A request is one rising edge of its input. An input held high for many cycles counts once.
- R7: A carry and a borrow whose rising edges reach the block in the same cycle cancel each other. The output keeps strictly alternating.
- R8: While reset (rstN low, asynchronous) is asserted, the output is low. Reset clears every pending request, including one still inside the synchroniser.
- R9: Count the cycles from reset up to an output pulse taken after all requests are serviced, including the reset cycle. Twice the pulse count then equals that cycle count plus carries minus borrows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/D clock; every register runs on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| carryReq | input | 1 | Carry request; each rising edge asks for one added pulse |
| borrowReq | input | 1 | Borrow request; each rising edge asks for one removed pulse |
| idOut | output | 1 | Output pulse train, high only during I/D clock low phases |

## Verification
The bench sweeps every combination of zero to three carries followed by zero to three borrows. For each combination it counts the pairs of neighbouring high and low phases, which shows that each request has exactly one effect and in the right direction. It also checks the rate formula, which would catch pulses gained or lost elsewhere. Separate runs cover:
- a carry input held high for many cycles, which tells edge detection apart from level sensing;
- requests spaced one cycle apart, which shows that pending requests accumulate;
- carries and borrows raised in the same cycle, which shows they cancel;
- a mixed close-spaced sequence;
- a reset that lands while a request is still in the synchroniser.

// File: rtl/idAdjPkg.sv
package idAdjPkg;
  // Strobes from control to datapath, one set per I/D clock cycle.
  typedef struct packed {
    logic              holdPhase;  // keep the phase bit across this edge
    logic signed [2:0] netDelta;   // change of the pending count, -2..+2
  } idStrobeT;
endpackage

// File: rtl/idReqSync.sv
module idReqSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqAsync,
  output logic reqEdge
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          lastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      lastQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[LAST-1:0], reqAsync};
      lastQ <= syncQ[LAST];
    end
  end

  assign reqEdge = syncQ[LAST] & ~lastQ;
endmodule

// File: rtl/idPulseControl.sv
module idPulseControl
  import idAdjPkg::*;
(
  input  logic     carryEdge,
  input  logic     borrowEdge,
  input  logic     netPos,
  input  logic     netNeg,
  input  logic     tState,
  output idStrobeT strobe
);
  logic serviceUp;
  logic serviceDn;

  // An addition can only be served while the phase bit is high,
  // a deletion only while it is low.
  assign serviceUp = netPos & tState;
  assign serviceDn = netNeg & ~tState;

  always_comb begin
    strobe.holdPhase = serviceUp | serviceDn;
    strobe.netDelta  = 3'(carryEdge) + 3'(serviceDn)
                     - 3'(borrowEdge) - 3'(serviceUp);
  end
endmodule

// File: rtl/idPulseDatapath.sv
module idPulseDatapath
  import idAdjPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NET_W       = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     carryReq,
  input  logic     borrowReq,
  input  idStrobeT strobe,
  output logic     carryEdge,
  output logic     borrowEdge,
  output logic     netPos,
  output logic     netNeg,
  output logic     tState,
  output logic     idOut
);
  localparam int WIDE_W = NET_W + 2;
  localparam logic signed [WIDE_W-1:0] WIDE_MAX = WIDE_W'((2 ** (NET_W - 1)) - 1);
  localparam logic signed [WIDE_W-1:0] WIDE_MIN = -WIDE_MAX - WIDE_W'(1);

  logic [1:0] reqIn;
  logic [1:0] reqEdges;

  assign reqIn = {borrowReq, carryReq};

  generate
    for (genvar ch = 0; ch < 2; ch++) begin : g_reqSync
      idReqSync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rstN    (rstN),
        .reqAsync(reqIn[ch]),
        .reqEdge (reqEdges[ch])
      );
    end
  endgenerate

  assign carryEdge  = reqEdges[0];
  assign borrowEdge = reqEdges[1];

  logic signed [NET_W-1:0]  netQ;
  logic signed [WIDE_W-1:0] netWide;
  logic signed [WIDE_W-1:0] netNext;

  always_comb begin
    netWide = {{2{netQ[NET_W-1]}}, netQ}
            + {{(WIDE_W-3){strobe.netDelta[2]}}, strobe.netDelta};
    if (netWide > WIDE_MAX)      netNext = WIDE_MAX;
    else if (netWide < WIDE_MIN) netNext = WIDE_MIN;
    else                         netNext = netWide;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      netQ   <= '0;
      tState <= 1'b0;
    end else begin
      netQ <= netNext[NET_W-1:0];
      if (!strobe.holdPhase) tState <= ~tState;
    end
  end

  assign netNeg = netQ[NET_W-1];
  assign netPos = ~netQ[NET_W-1] & (|netQ);

  // A pulse occupies the low half of the I/D clock cycle selected by tState.
  assign idOut = tState & ~clk;
endmodule

// File: rtl/idPulseAdjuster.sv
module idPulseAdjuster
  import idAdjPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NET_W       = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic carryReq,
  input  logic borrowReq,
  output logic idOut
);
  idStrobeT strobe;
  logic     carryEdge;
  logic     borrowEdge;
  logic     netPos;
  logic     netNeg;
  logic     tState;

  idPulseDatapath #(.SYNC_STAGES(SYNC_STAGES), .NET_W(NET_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .carryReq  (carryReq),
    .borrowReq (borrowReq),
    .strobe    (strobe),
    .carryEdge (carryEdge),
    .borrowEdge(borrowEdge),
    .netPos    (netPos),
    .netNeg    (netNeg),
    .tState    (tState),
    .idOut     (idOut)
  );

  idPulseControl u_ctl (
    .carryEdge (carryEdge),
    .borrowEdge(borrowEdge),
    .netPos    (netPos),
    .netNeg    (netNeg),
    .tState    (tState),
    .strobe    (strobe)
  );
endmodule

// File: rtl/idPulseAdjusterChecker.sv
module idPulseAdjusterChecker (
  input logic clk,
  input logic rstN,
  input logic tState,
  input logic netPos,
  input logic netNeg,
  input logic holdPhase,
  input logic carryEdge,
  input logic borrowEdge
);
  p_idle_toggle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!netPos && !netNeg) |=> (tState != $past(tState)));

  p_add_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (netPos && tState) |=> tState);

  p_del_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (netNeg && !tState) |=> !tState);

  p_hold_pending_r5: assert property (@(posedge clk) disable iff (!rstN)
    holdPhase |-> (netPos || netNeg));

  p_cancel_r7: assert property (@(posedge clk) disable iff (!rstN)
    (carryEdge && borrowEdge && !netPos && !netNeg) |=> (!netPos && !netNeg));

  p_reset_clear_r8: assert property (@(posedge clk)
    $rose(rstN) |-> (!tState && !netPos && !netNeg));
endmodule

bind idPulseAdjuster idPulseAdjusterChecker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tState    (tState),
  .netPos    (netPos),
  .netNeg    (netNeg),
  .holdPhase (strobe.holdPhase),
  .carryEdge (carryEdge),
  .borrowEdge(borrowEdge)
);

// File: tb/idPulseAdjuster_test.sv
module idPulseAdjuster_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic carryReq = 1'b0;
  logic borrowReq = 1'b0;
  logic idOut;

  int checks = 0;
  int errors = 0;
  int cyc, pulses, h1, h0, highBad;
  logic prevS;

  idPulseAdjuster uut (
    .clk(clk), .rstN(rstN), .carryReq(carryReq), .borrowReq(borrowReq), .idOut(idOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One I/D cycle: check the high phase, drive inputs at the falling edge,
  // sample the low phase.
  task automatic stepCycle(input logic c, input logic b);
    logic s;
    @(posedge clk);
    #(CLK_PERIOD / 5);
    if (idOut !== 1'b0) highBad++;
    #(3 * CLK_PERIOD / 10);
    carryReq = c;
    borrowReq = b;
    #(CLK_PERIOD / 5);
    s = idOut;
    cyc++;
    if (s) pulses++;
    if (s == prevS) begin
      if (s) h1++;
      else h0++;
    end
    prevS = s;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    carryReq = 1'b0;
    borrowReq = 1'b0;
    #1;
    check(idOut === 1'b0, "R8 output low in reset", idOut, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    cyc = 1;  // the reset cycle counts as one low sample
    pulses = 0;
    h1 = 0;
    h0 = 0;
    highBad = 0;
    prevS = 1'b0;
  endtask

  task automatic finishWindow(input int nc, input int nb);
    repeat (30) stepCycle(1'b0, 1'b0);
    for (int k = 0; k < 4 && !prevS; k++) stepCycle(1'b0, 1'b0);
    check(2 * pulses == cyc + nc - nb, "R9 rate formula", 2 * pulses, cyc + nc - nb);
    check(highBad == 0, "R2 low during clock high", highBad, 0);
  endtask

  initial begin
    // R1 idle half rate
    doReset();
    stepCycle(1'b0, 1'b0);
    check(prevS == 1'b1, "R1 first pulse after reset", prevS, 1);
    repeat (39) stepCycle(1'b0, 1'b0);
    check(h1 + h0 == 0, "R1 strict alternation", h1 + h0, 0);
    check(pulses == 20, "R1 pulse count over 40 cycles", pulses, 20);
    finishWindow(0, 0);

    // R3 / R4 sweep over carry and borrow counts
    for (int nc = 0; nc < 4; nc++) begin
      for (int nb = 0; nb < 4; nb++) begin
        doReset();
        for (int i = 0; i < nc; i++) begin
          stepCycle(1'b1, 1'b0);
          stepCycle(1'b0, 1'b0);
          stepCycle(1'b0, 1'b0);
        end
        repeat (12) stepCycle(1'b0, 1'b0);
        for (int i = 0; i < nb; i++) begin
          stepCycle(1'b0, 1'b1);
          stepCycle(1'b0, 1'b0);
          stepCycle(1'b0, 1'b0);
        end
        finishWindow(nc, nb);
        check(h1 == nc, "R3 one extra pulse per carry", h1, nc);
        check(h0 == nb, "R4 one removed pulse per borrow", h0, nb);
      end
    end

    // R5 back-to-back carries then borrows, one cycle apart
    doReset();
    repeat (6) begin
      stepCycle(1'b1, 1'b0);
      stepCycle(1'b0, 1'b0);
    end
    finishWindow(6, 0);
    check(h1 == 6, "R5 back-to-back carries kept", h1, 6);
    doReset();
    repeat (5) begin
      stepCycle(1'b0, 1'b1);
      stepCycle(1'b0, 1'b0);
    end
    finishWindow(0, 5);
    check(h0 == 5, "R5 back-to-back borrows kept", h0, 5);

    // R5 mixed close-spaced sequence: 4 carries, 3 borrows
    doReset();
    stepCycle(1'b1, 1'b0); stepCycle(1'b0, 1'b0);
    stepCycle(1'b0, 1'b1); stepCycle(1'b0, 1'b0);
    stepCycle(1'b1, 1'b0); stepCycle(1'b0, 1'b0);
    stepCycle(1'b1, 1'b0); stepCycle(1'b0, 1'b0); stepCycle(1'b0, 1'b0);
    stepCycle(1'b0, 1'b1); stepCycle(1'b0, 1'b0);
    stepCycle(1'b1, 1'b0); stepCycle(1'b0, 1'b0);
    stepCycle(1'b0, 1'b1); stepCycle(1'b0, 1'b0);
    finishWindow(4, 3);
    check(h1 - h0 == 1, "R5 mixed net effect", h1 - h0, 1);

    // R6 held-high carry counts once
    doReset();
    repeat (20) stepCycle(1'b1, 1'b0);
    finishWindow(1, 0);
    check(h1 == 1, "R6 held carry counts once", h1, 1);
    doReset();
    repeat (20) stepCycle(1'b0, 1'b1);
    finishWindow(0, 1);
    check(h0 == 1, "R6 held borrow counts once", h0, 1);

    // R7 simultaneous carry and borrow cancel
    doReset();
    repeat (4) begin
      stepCycle(1'b1, 1'b1);
      stepCycle(1'b0, 1'b0);
    end
    finishWindow(0, 0);
    check(h1 + h0 == 0, "R7 simultaneous requests cancel", h1 + h0, 0);

    // R8 reset drops a request still in flight
    doReset();
    stepCycle(1'b1, 1'b0);
    doReset();
    finishWindow(0, 0);
    check(h1 == 0, "R8 pending carry cleared by reset", h1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule